// File: doc/BRIEF.md
# Page Access Permission and Fault Classifier

This block sits after the page-table search of a 32-bit segmented memory management unit. Each request carries one finished lookup: the kind of access, the privilege level, the protection bits from the segment descriptor, the 2-bit page protection code from the matching entry, a flag that says the search found no entry, and the effective address. The block works out which rights the page grants and decides whether the access may go ahead. When it may not, it classifies the fault as an instruction-storage fault or a data-storage fault. It also produces the fixed status word for that fault and, on the data side, records the faulting address.

A request is one cycle with `in_valid` high. The verdict appears on registered outputs one cycle later, marked by a single-cycle `out_valid` pulse. The outputs keep their values until the next request. Segments marked for direct-store get their own simplified check, and the table result is not used for them.

Top module: `mmu_perm_check`

## Requirements
- R1: The protection key is `seg_kp` when `in_user` is 1 and `seg_ks` when `in_user` is 0.
- R2: With key 0 on a translated page, `page_pp` codes 0, 1 and 2 grant read and write, and code 3 grants read only.
- R3: With key 1 on a translated page, `page_pp` 0 grants neither read nor write, codes 1 and 3 grant read only, and code 2 grants read and write.
- R4: `grant_x` is 1 only for a translated page that was found, with `seg_nx` clear. It is never 1 when `seg_nx` is set, on a miss, or in a direct-store segment.
- R5: A fetch (`in_kind` = 2) from a segment with `seg_nx` or `seg_direct` set faults as an instruction fault with status 0x10000000. This check takes priority over a lookup miss and over the page rights.
- R6: A lookup miss (`walk_miss` = 1, `seg_direct` = 0) grants no rights and faults. A fetch gets status 0x40000000 as an instruction fault. A load (`in_kind` = 0) gets 0x40000000 and a store (`in_kind` = 1) gets 0x42000000, both as data faults.
- R7: If the right an access needs is missing from the granted set, the access faults. A load needs read, a store needs write and a fetch needs execute. A fetch gets status 0x08000000 as an instruction fault. A load gets 0x08000000 and a store gets 0x0A000000, both as data faults (`fault_is_data` = 1).
- R8: Every data fault loads `eff_addr` into `fault_addr`. Instruction faults and accesses that do not fault leave `fault_addr` unchanged.
- R9: In a direct-store segment, `walk_miss` and `page_pp` have no effect. The rights are read = !key, write = key and execute = 0. A load is allowed only with key 0 and a store only with key 1. Otherwise the access takes the protection-fault status from R7.
- R10: `out_valid` pulses one cycle after each `in_valid` cycle, and the result outputs keep their values between requests. A synchronous reset clears `out_valid`, the grants, `fault`, `fault_is_data`, `syndrome` and `fault_addr`.
- R11: An allowed access reports `fault` = 0, `fault_is_data` = 0 and `syndrome` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle request strobe |
| in_kind | input | 2 | 0 load, 1 store, 2 instruction fetch |
| in_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| seg_ks | input | 1 | Supervisor key bit of the segment |
| seg_kp | input | 1 | User key bit of the segment |
| seg_nx | input | 1 | Segment no-execute bit |
| seg_direct | input | 1 | Segment is a direct-store segment |
| page_pp | input | 2 | Page protection code from the table entry |
| walk_miss | input | 1 | Table search found no entry |
| eff_addr | input | ADDR_W | Effective address of the access |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| grant_r | output | 1 | Read granted |
| grant_w | output | 1 | Write granted |
| grant_x | output | 1 | Execute granted |
| fault | output | 1 | Access denied |
| fault_is_data | output | 1 | 1 = data-storage fault, 0 = instruction-storage fault |
| syndrome | output | 32 | Fault status word, 0 when allowed |
| fault_addr | output | ADDR_W | Address of the most recent data fault |

## Verification
The assertions assume `in_kind` never takes the reserved value 3, because the fetch and store checks key off the exact code. The vector table and the directed tests only ever drive 0, 1 or 2. The assertions also assume reset is held for at least one clock before the first request. The bench does this, and it only raises `in_valid` after reset has been released. Segment and page fields are driven at the negative edge, so each request presents a complete, stable set of inputs in the cycle its strobe is sampled.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_NOEXEC = 2'd1,
        FK_MISS   = 2'd2,
        FK_PROT   = 2'd3
    } fault_kind_e;

    localparam int SYND_W = 32;

    localparam logic [SYND_W-1:0] SYN_CLEAR    = 32'h0000_0000;
    localparam logic [SYND_W-1:0] SYN_NOEXEC   = 32'h1000_0000;
    localparam logic [SYND_W-1:0] SYN_MISS_RD  = 32'h4000_0000;
    localparam logic [SYND_W-1:0] SYN_MISS_WR  = 32'h4200_0000;
    localparam logic [SYND_W-1:0] SYN_PROT_RD  = 32'h0800_0000;
    localparam logic [SYND_W-1:0] SYN_PROT_WR  = 32'h0A00_0000;

    // Read/write rights for a translated page from key and protection code
    function automatic rights_t page_rights(input logic key,
                                            input logic [1:0] pp,
                                            input logic nx);
        rights_t r;
        r = '0;
        if (!key) begin
            r.rd = 1'b1;
            r.wr = (pp != 2'd3);
        end else begin
            unique case (pp)
                2'd0:    begin r.rd = 1'b0; r.wr = 1'b0; end
                2'd2:    begin r.rd = 1'b1; r.wr = 1'b1; end
                default: begin r.rd = 1'b1; r.wr = 1'b0; end
            endcase
        end
        r.ex = !nx;
        return r;
    endfunction

    // Right that a given access kind requires
    function automatic rights_t needed_rights(input acc_kind_e k);
        rights_t n;
        n = '0;
        unique case (k)
            ACC_STORE: n.wr = 1'b1;
            ACC_FETCH: n.ex = 1'b1;
            default:   n.rd = 1'b1;
        endcase
        return n;
    endfunction

    // Fixed status word per fault kind and direction
    function automatic logic [SYND_W-1:0] status_word(input fault_kind_e f,
                                                      input logic is_store);
        logic [SYND_W-1:0] s;
        unique case (f)
            FK_NOEXEC: s = SYN_NOEXEC;
            FK_MISS:   s = is_store ? SYN_MISS_WR : SYN_MISS_RD;
            FK_PROT:   s = is_store ? SYN_PROT_WR : SYN_PROT_RD;
            default:   s = SYN_CLEAR;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mmu_perm_rights.sv
module mmu_perm_rights
    import mmu_perm_pkg::*;
(
    input  logic       priv_user,
    input  logic       key_sup,
    input  logic       key_usr,
    input  logic       no_exec,
    input  logic       direct,
    input  logic       miss,
    input  logic [1:0] pp,
    output logic       key,
    output rights_t    granted
);

    always_comb begin
        key = priv_user ? key_usr : key_sup;
    end

    always_comb begin
        if (direct) begin
            // direct-store segment: table result unused, no execute
            granted.rd = !key;
            granted.wr = key;
            granted.ex = 1'b0;
        end else if (miss) begin
            granted = '0;
        end else begin
            granted = page_rights(key, pp, no_exec);
        end
    end

endmodule

// File: rtl/mmu_perm_classify.sv
module mmu_perm_classify
    import mmu_perm_pkg::*;
(
    input  acc_kind_e          kind,
    input  logic               no_exec,
    input  logic               direct,
    input  logic               miss,
    input  logic               key,
    input  rights_t            granted,
    output logic               fault,
    output logic               on_data,
    output logic [SYND_W-1:0]  status
);

    logic        is_fetch;
    logic        is_store;
    logic        lacking;
    logic        ds_allowed;
    rights_t     need;
    fault_kind_e fk;

    always_comb begin
        is_fetch   = (kind == ACC_FETCH);
        is_store   = (kind == ACC_STORE);
        need       = needed_rights(kind);
        lacking    = |(need & ~granted);
        ds_allowed = is_store ? key : !key;
    end

    // Priority: no-execute/direct fetch, direct-store check, miss, rights
    always_comb begin
        if (is_fetch && (direct || no_exec)) begin
            fk = FK_NOEXEC;
        end else if (direct) begin
            fk = ds_allowed ? FK_NONE : FK_PROT;
        end else if (miss) begin
            fk = FK_MISS;
        end else if (lacking) begin
            fk = FK_PROT;
        end else begin
            fk = FK_NONE;
        end
    end

    always_comb begin
        fault   = (fk != FK_NONE);
        on_data = fault && !is_fetch;
        status  = status_word(fk, is_store);
    end

endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
    import mmu_perm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic              in_user,
    input  logic              seg_ks,
    input  logic              seg_kp,
    input  logic              seg_nx,
    input  logic              seg_direct,
    input  logic [1:0]        page_pp,
    input  logic              walk_miss,
    input  logic [ADDR_W-1:0] eff_addr,
    output logic              out_valid,
    output logic              grant_r,
    output logic              grant_w,
    output logic              grant_x,
    output logic              fault,
    output logic              fault_is_data,
    output logic [31:0]       syndrome,
    output logic [ADDR_W-1:0] fault_addr
);

    acc_kind_e         kind;
    logic              key;
    rights_t           granted;
    logic              c_fault;
    logic              c_data;
    logic [SYND_W-1:0] c_status;

    always_comb begin
        kind = acc_kind_e'(in_kind);
    end

    mmu_perm_rights u_rights (
        .priv_user (in_user),
        .key_sup   (seg_ks),
        .key_usr   (seg_kp),
        .no_exec   (seg_nx),
        .direct    (seg_direct),
        .miss      (walk_miss),
        .pp        (page_pp),
        .key       (key),
        .granted   (granted)
    );

    mmu_perm_classify u_classify (
        .kind    (kind),
        .no_exec (seg_nx),
        .direct  (seg_direct),
        .miss    (walk_miss),
        .key     (key),
        .granted (granted),
        .fault   (c_fault),
        .on_data (c_data),
        .status  (c_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            grant_r       <= 1'b0;
            grant_w       <= 1'b0;
            grant_x       <= 1'b0;
            fault         <= 1'b0;
            fault_is_data <= 1'b0;
            syndrome      <= '0;
            fault_addr    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                grant_r       <= granted.rd;
                grant_w       <= granted.wr;
                grant_x       <= granted.ex;
                fault         <= c_fault;
                fault_is_data <= c_data;
                syndrome      <= c_status;
                if (c_data) begin
                    fault_addr <= eff_addr;
                end
            end
        end
    end

    // R10: strobe follows request by exactly one cycle
    a_r10_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r10_idle_next: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: no execute right in a no-execute segment
    a_r4_no_exec_grant: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(seg_nx) |-> !grant_x);

    // R5: fetch faults are always instruction faults
    a_r5_fetch_is_instr: assert property (@(posedge clk) disable iff (rst)
        out_valid && fault && ($past(in_kind) == 2'd2) |-> !fault_is_data);

    // R6: a miss on a translated segment grants nothing
    a_r6_miss_no_rights: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(walk_miss) && !$past(seg_direct)
        |-> !grant_r && !grant_w && !grant_x && fault);

    // R7: an allowed store always holds write permission
    a_r7_store_has_write: assert property (@(posedge clk) disable iff (rst)
        out_valid && !fault && ($past(in_kind) == 2'd1) |-> grant_w);

    // R8: data faults capture the address of their request
    a_r8_addr_capture: assert property (@(posedge clk) disable iff (rst)
        out_valid && fault && fault_is_data |-> fault_addr == $past(eff_addr));
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !(out_valid && fault && fault_is_data) |-> $stable(fault_addr));

    // R11: allowed access reports a clean status
    a_r11_clean_status: assert property (@(posedge clk) disable iff (rst)
        out_valid && !fault |-> (syndrome == 32'h0) && !fault_is_data);

endmodule

// File: tb/mmu_perm_check_bench.sv
module mmu_perm_check_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = 2'd0;
    logic        in_user = 1'b0;
    logic        seg_ks = 1'b0;
    logic        seg_kp = 1'b0;
    logic        seg_nx = 1'b0;
    logic        seg_direct = 1'b0;
    logic [1:0]  page_pp = 2'd0;
    logic        walk_miss = 1'b0;
    logic [31:0] eff_addr = 32'h0;
    logic        out_valid, grant_r, grant_w, grant_x, fault, fault_is_data;
    logic [31:0] syndrome;
    logic [31:0] fault_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] exp_fa = 32'h0;

    always #2 clk = ~clk;

    mmu_perm_check u_mmu_perm_check (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_user(in_user), .seg_ks(seg_ks), .seg_kp(seg_kp), .seg_nx(seg_nx),
        .seg_direct(seg_direct), .page_pp(page_pp), .walk_miss(walk_miss),
        .eff_addr(eff_addr), .out_valid(out_valid), .grant_r(grant_r),
        .grant_w(grant_w), .grant_x(grant_x), .fault(fault),
        .fault_is_data(fault_is_data), .syndrome(syndrome),
        .fault_addr(fault_addr)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic        usr;
        logic        ks;
        logic        kp;
        logic        nx;
        logic        ds;
        logic [1:0]  pp;
        logic        miss;
        logic        er;
        logic        ew;
        logic        ex;
        logic        ef;
        logic        ed;
        logic [31:0] code;
    } vec_t;

    localparam int NV = 23;
    // kind,usr,ks,kp,nx,ds,pp,miss | r,w,x,fault,data,code
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,32'h0},         // R1 R2 sup uses Ks
        '{2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b1,32'h0A00_0000}, // R1 R3 R7
        '{2'd0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b0,1'b1,1'b1,1'b1,32'h0800_0000}, // R3 R7
        '{2'd2,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},         // R4 R11
        '{2'd1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd2,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,32'h0},         // R3
        '{2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,2'd3,1'b0, 1'b1,1'b0,1'b1,1'b1,1'b1,32'h0A00_0000}, // R2 R7
        '{2'd0,1'b1,1'b1,1'b0,1'b1,1'b0,2'd3,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},         // R4
        '{2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,1'b0, 1'b1,1'b1,1'b0,1'b1,1'b0,32'h1000_0000}, // R5
        '{2'd2,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,32'h1000_0000}, // R5 over miss
        '{2'd2,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b0,32'h4000_0000}, // R6
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,32'h4000_0000}, // R6
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,32'h4200_0000}, // R6
        '{2'd2,1'b0,1'b1,1'b0,1'b0,1'b0,2'd1,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,32'h0},         // R3 R4
        '{2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,2'd1,1'b0, 1'b1,1'b0,1'b1,1'b1,1'b1,32'h0A00_0000}, // R3 R7
        '{2'd2,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b0,32'h1000_0000}, // R5 R9
        '{2'd0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},         // R9 miss ignored
        '{2'd1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b1,32'h0A00_0000}, // R9
        '{2'd1,1'b1,1'b0,1'b1,1'b0,1'b1,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,32'h0},         // R9
        '{2'd0,1'b1,1'b0,1'b1,1'b0,1'b1,2'd0,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b1,32'h0800_0000}, // R9
        '{2'd1,1'b0,1'b0,1'b1,1'b1,1'b0,2'd2,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0,32'h0},         // R2 R4
        '{2'd0,1'b1,1'b1,1'b0,1'b0,1'b0,2'd1,1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,32'h0},         // R1 R2
        '{2'd1,1'b1,1'b0,1'b1,1'b0,1'b0,2'd3,1'b0, 1'b1,1'b0,1'b1,1'b1,1'b1,32'h0A00_0000}, // R3 R7
        '{2'd0,1'b0,1'b1,1'b0,1'b0,1'b0,2'd1,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,32'h0}          // R3 R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic [31:0] addr);
        in_kind    = v.kind;
        in_user    = v.usr;
        seg_ks     = v.ks;
        seg_kp     = v.kp;
        seg_nx     = v.nx;
        seg_direct = v.ds;
        page_pp    = v.pp;
        walk_miss  = v.miss;
        eff_addr   = addr;
    endtask

    task automatic check_result(input vec_t v, input logic [31:0] addr, input int idx);
        string s;
        if (v.ef && v.ed) exp_fa = addr;
        s = $sformatf("vec%0d", idx);
        chk({"R10 out_valid ", s}, {31'b0, out_valid}, 32'd1);
        chk({"R1/R2/R3/R4/R9 rights ", s}, {29'b0, grant_r, grant_w, grant_x},
            {29'b0, v.er, v.ew, v.ex});
        chk({"R5/R6/R7/R9 fault ", s}, {31'b0, fault}, {31'b0, v.ef});
        chk({"R5/R6/R7/R11 class ", s}, {31'b0, fault_is_data}, {31'b0, v.ed});
        chk({"R5/R6/R7/R11 code ", s}, syndrome, v.code);
        chk({"R8 fault_addr ", s}, fault_addr, exp_fa);
    endtask

    task automatic run_one(input vec_t v, input logic [31:0] addr, input int idx);
        @(negedge clk);
        drive(v, addr);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_result(v, addr, idx);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10 reset out_valid", {31'b0, out_valid}, 32'd0);
        chk("R10 reset grants", {29'b0, grant_r, grant_w, grant_x}, 32'd0);
        chk("R10 reset fault", {30'b0, fault, fault_is_data}, 32'd0);
        chk("R10 reset syndrome", syndrome, 32'd0);
        chk("R10 reset fault_addr", fault_addr, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i], 32'hA000_0000 + 32'(i) * 32'h0000_1010, i);
        end

        // R10: outputs hold, strobe stays low while idle
        repeat (3) @(negedge clk);
        chk("R10 idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R10 hold fault", {31'b0, fault}, {31'b0, VECS[NV-1].ef});
        chk("R10 hold grants", {29'b0, grant_r, grant_w, grant_x},
            {29'b0, VECS[NV-1].er, VECS[NV-1].ew, VECS[NV-1].ex});
        chk("R8 hold fault_addr", fault_addr, exp_fa);

        // R8: instruction fault does not move fault_addr
        run_one(VECS[9], 32'h1234_5678, 100);

        // back-to-back requests: data fault then allowed access
        @(negedge clk);
        drive(VECS[11], 32'h5555_0000);
        in_valid = 1'b1;
        @(negedge clk);
        check_result(VECS[11], 32'h5555_0000, 101);
        drive(VECS[0], 32'h6666_0000);
        @(negedge clk);
        in_valid = 1'b0;
        check_result(VECS[0], 32'h6666_0000, 102);

        // R10: reset in mid-run clears the fault record
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 mid reset fault_addr", fault_addr, 32'd0);
        chk("R10 mid reset syndrome", syndrome, 32'd0);
        chk("R10 mid reset out_valid", {31'b0, out_valid}, 32'd0);
        exp_fa = 32'h0;
        run_one(VECS[10], 32'h7777_0004, 103);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule